// File: doc/BRIEF.md
# Dimension-Order Route Computation for a 2-D Mesh or Torus Switch

This block computes the output port for one switch of a two-dimensional k-ary network. It accepts a packet header with a destination coordinate pair through a valid/ready handshake. It compares that pair with the switch's own coordinates, which are strapped on input pins. It then presents a registered, one-hot port select naming one of five outputs: positive X, negative X, positive Y, negative Y, or local eject.

Routing is deterministic and always finishes one dimension before the next. As long as the X coordinates differ, an X port is chosen whatever Y says. A Y port is chosen only once X matches, and eject is chosen when both match. This fixed ordering is what keeps channel allocation free of cycles.

Per-dimension offsets are signed, one bit wider than a coordinate, and formed as destination minus local. In mesh mode the offset's sign sets the direction. With the `TORUS` parameter set, the shorter way around each ring is taken, and an exact half-ring tie goes positive. A downstream consumer takes the select by raising `sel_ack`. Until it does, the select is held and no new header is accepted.

Top module: `dor_route_unit`

## Requirements
- R1: While and right after `rst` is high, `port_vld` is 0, `port_sel` is 0 and `hdr_ready` is 1.
- R2: A header accepted on a clock edge (`hdr_valid` and `hdr_ready` both high) appears on that edge as `port_vld`=1 with exactly one bit of `port_sel` set. Bit 0 is eject, bit 1 positive X, bit 2 negative X, bit 3 positive Y and bit 4 negative Y.
- R3: When the destination X differs from the local X, the select is bit 1 or bit 2, whatever the Y coordinates are.
- R4: When X matches and Y differs, the select is bit 3 or bit 4.
- R5: When both coordinates match, the select is bit 0 (eject).
- R6: In mesh mode (`TORUS`=0), the positive port of a dimension is chosen when destination minus local is above zero, and the negative port when it is below zero.
- R7: In torus mode (`TORUS`=1), the direction with the fewer hops around the ring of size K is chosen. When both ways are K/2 hops, the positive port is chosen.
- R8: While `port_vld` is 1 and `sel_ack` is 0, `hdr_ready` is 0, `port_sel` holds its value, and an offered header is not taken. With `sel_ack` at 1, a new header is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken this cycle |
| hdr_dst_x | input | clog2(K_X) | Destination X coordinate |
| hdr_dst_y | input | clog2(K_Y) | Destination Y coordinate |
| here_x | input | clog2(K_X) | This switch's X coordinate (static) |
| here_y | input | clog2(K_Y) | This switch's Y coordinate (static) |
| sel_ack | input | 1 | Consumer takes the current port select |
| port_vld | output | 1 | Port select is valid |
| port_sel | output | 5 | One-hot output port select |

## Verification
Two events can fall in the same cycle: the consumer retiring the held select and the block accepting the next header. They are provoked by exhaustive sweeps of every local/destination pair with `sel_ack` held high and a fresh header offered each cycle. Each new select must then replace the previous one with no idle cycle between them. The opposite case is also provoked: `sel_ack` is held low while a second header is offered. The select is then judged at the ports to be unchanged and the second header to be taken only after `sel_ack` rises.

// File: rtl/dor_pkg.sv
package dor_pkg;
  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_PLUS  = 2'd1,
    DIR_MINUS = 2'd2
  } dir_e;

  localparam int PORT_N     = 5;
  localparam int PORT_EJECT = 0;
  localparam int PORT_XP    = 1;
  localparam int PORT_XM    = 2;
  localparam int PORT_YP    = 3;
  localparam int PORT_YM    = 4;
endpackage

// File: rtl/dor_dim_resolver.sv
module dor_dim_resolver
  import dor_pkg::*;
#(
  parameter int K     = 4,
  parameter bit TORUS = 1'b0,
  localparam int CW   = (K > 1) ? $clog2(K) : 1
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] dst,
  output dir_e          dir
);
  localparam int OW = CW + 1;
  localparam logic [OW:0] K_REF = (OW+1)'(K);

  logic signed [OW-1:0] ofs;
  logic        [OW-1:0] mag;
  logic        [OW:0]   mag_x2;
  logic                 neg;

  always_comb begin
    ofs    = $signed({1'b0, dst}) - $signed({1'b0, cur});
    neg    = ofs[OW-1];
    mag    = neg ? $unsigned(-ofs) : $unsigned(ofs);
    mag_x2 = {mag, 1'b0};
  end

  generate
    if (TORUS) begin : g_ring
      always_comb begin
        if (mag == '0)            dir = DIR_NONE;
        else if (mag_x2 == K_REF) dir = DIR_PLUS;
        else if (mag_x2 > K_REF)  dir = neg ? DIR_PLUS : DIR_MINUS;
        else                      dir = neg ? DIR_MINUS : DIR_PLUS;
      end

      // R7: chosen way is never the longer way round the ring
      always_comb begin : chk_ring
        int fwd;
        fwd = (int'(dst) + K - int'(cur)) % K;
        if (!$isunknown({cur, dst}) && int'(cur) < K && int'(dst) < K) begin
          if (dir == DIR_PLUS)
            a_r7_plus_shorter: assert (fwd != 0 && 2 * fwd <= K);
          if (dir == DIR_MINUS)
            a_r7_minus_shorter: assert (fwd != 0 && 2 * fwd > K);
          if (dir == DIR_NONE)
            a_r7_none_at_home: assert (fwd == 0);
        end
      end
    end else begin : g_line
      always_comb begin
        if (mag == '0) dir = DIR_NONE;
        else           dir = neg ? DIR_MINUS : DIR_PLUS;
      end

      // R6: mesh direction follows the sign of the offset
      always_comb begin : chk_line
        if (!$isunknown({cur, dst})) begin
          if (dir == DIR_PLUS)  a_r6_plus_ahead:  assert (dst > cur);
          if (dir == DIR_MINUS) a_r6_minus_behind: assert (dst < cur);
          if (dir == DIR_NONE)  a_r6_none_equal:  assert (dst == cur);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dor_port_select.sv
module dor_port_select
  import dor_pkg::*;
(
  input  dir_e              x_dir,
  input  dir_e              y_dir,
  output logic [PORT_N-1:0] sel
);
  always_comb begin
    sel = '0;
    if (x_dir == DIR_PLUS)       sel[PORT_XP]    = 1'b1;
    else if (x_dir == DIR_MINUS) sel[PORT_XM]    = 1'b1;
    else if (y_dir == DIR_PLUS)  sel[PORT_YP]    = 1'b1;
    else if (y_dir == DIR_MINUS) sel[PORT_YM]    = 1'b1;
    else                         sel[PORT_EJECT] = 1'b1;
  end
endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
  import dor_pkg::*;
#(
  parameter int K_X    = 4,
  parameter int K_Y    = 4,
  parameter bit TORUS  = 1'b0,
  localparam int XW    = (K_X > 1) ? $clog2(K_X) : 1,
  localparam int YW    = (K_Y > 1) ? $clog2(K_Y) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [XW-1:0]     hdr_dst_x,
  input  logic [YW-1:0]     hdr_dst_y,
  input  logic [XW-1:0]     here_x,
  input  logic [YW-1:0]     here_y,
  input  logic              sel_ack,
  output logic              port_vld,
  output logic [PORT_N-1:0] port_sel
);
  dir_e              x_dir;
  dir_e              y_dir;
  logic [PORT_N-1:0] sel_nxt;
  logic              hdr_fire;

  dor_dim_resolver #(.K(K_X), .TORUS(TORUS)) i_res_x (
    .cur (here_x),
    .dst (hdr_dst_x),
    .dir (x_dir)
  );

  dor_dim_resolver #(.K(K_Y), .TORUS(TORUS)) i_res_y (
    .cur (here_y),
    .dst (hdr_dst_y),
    .dir (y_dir)
  );

  dor_port_select i_sel (
    .x_dir (x_dir),
    .y_dir (y_dir),
    .sel   (sel_nxt)
  );

  assign hdr_ready = !port_vld || sel_ack;
  assign hdr_fire  = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_vld <= 1'b0;
      port_sel <= '0;
    end else if (hdr_fire) begin
      port_vld <= 1'b1;
      port_sel <= sel_nxt;
    end else if (sel_ack) begin
      port_vld <= 1'b0;
      port_sel <= '0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!port_vld && port_sel == '0 && hdr_ready));

  a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
    port_vld |-> ($countones(port_sel) == 1));

  a_r2_fire_valid: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |=> port_vld);

  a_r3_x_first: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && hdr_dst_x != here_x) |=> (port_sel[PORT_XP] || port_sel[PORT_XM]));

  a_r4_y_after_x: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && hdr_dst_x == here_x && hdr_dst_y != here_y)
      |=> (port_sel[PORT_YP] || port_sel[PORT_YM]));

  a_r5_eject_home: assert property (@(posedge clk) disable iff (rst)
    (hdr_fire && hdr_dst_x == here_x && hdr_dst_y == here_y)
      |=> (port_sel == PORT_N'(1)));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (port_vld && !sel_ack) |=> (port_vld && $stable(port_sel)));
endmodule

// File: tb/test_dor_route_unit.sv
`timescale 1ns/1ps
module test_dor_route_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_ack = 1'b1;
  always #10 clk = ~clk;

  // mesh 4x4
  logic       m_valid = 1'b0;
  logic       m_ready;
  logic [1:0] m_dx = '0, m_dy = '0, m_hx = '0, m_hy = '0;
  logic       m_vld;
  logic [4:0] m_sel;
  // torus 4x3
  logic       t_valid = 1'b0;
  logic       t_ready;
  logic [1:0] t_dx = '0, t_dy = '0, t_hx = '0, t_hy = '0;
  logic       t_vld;
  logic [4:0] t_sel;

  dor_route_unit #(.K_X(4), .K_Y(4), .TORUS(1'b0)) i_dor_route_unit (
    .clk(clk), .rst(rst), .hdr_valid(m_valid), .hdr_ready(m_ready),
    .hdr_dst_x(m_dx), .hdr_dst_y(m_dy), .here_x(m_hx), .here_y(m_hy),
    .sel_ack(sel_ack), .port_vld(m_vld), .port_sel(m_sel));

  dor_route_unit #(.K_X(4), .K_Y(3), .TORUS(1'b1)) i_dor_route_unit_torus (
    .clk(clk), .rst(rst), .hdr_valid(t_valid), .hdr_ready(t_ready),
    .hdr_dst_x(t_dx), .hdr_dst_y(t_dy), .here_x(t_hx), .here_y(t_hy),
    .sel_ack(sel_ack), .port_vld(t_vld), .port_sel(t_sel));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 plus, 2 minus
  function automatic int dir_of(input int k, input bit ring, input int c, input int d);
    int f;
    if (!ring) return (d > c) ? 1 : (d < c) ? 2 : 0;
    f = (d - c + k) % k;
    if (f == 0) return 0;
    return (f <= k - f) ? 1 : 2;
  endfunction

  function automatic logic [4:0] exp_sel(input int kx, input int ky, input bit ring,
                                         input int hx, input int hy, input int dx, input int dy);
    int xd, yd;
    xd = dir_of(kx, ring, hx, dx);
    yd = dir_of(ky, ring, hy, dy);
    if (xd == 1) return 5'b00010;
    if (xd == 2) return 5'b00100;
    if (yd == 1) return 5'b01000;
    if (yd == 2) return 5'b10000;
    return 5'b00001;
  endfunction

  function automatic string tag_of(input bit ring, input int hx, input int hy, input int dx, input int dy);
    if (dx == hx && dy == hy) return ring ? "R5 eject (R7 ring)" : "R5 eject";
    if (dx != hx) return ring ? "R3/R7 ring X" : "R3/R6 mesh X";
    return ring ? "R4/R7 ring Y" : "R4/R6 mesh Y";
  endfunction

  initial begin
    logic [4:0] e;
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(m_vld == 1'b0 && m_sel == 5'b0, "R1 reset outputs", {m_vld, m_sel}, 0);
    check(m_ready == 1'b1, "R1 reset ready", m_ready, 1);
    rst = 1'b0;

    // mesh sweep, back-to-back headers with sel_ack high (R2, R8 same-cycle accept)
    for (int hx = 0; hx < 4; hx++)
      for (int hy = 0; hy < 4; hy++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++) begin
            m_hx = 2'(hx); m_hy = 2'(hy); m_dx = 2'(dx); m_dy = 2'(dy);
            m_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            e = exp_sel(4, 4, 1'b0, hx, hy, dx, dy);
            check(m_vld == 1'b1 && $countones(m_sel) == 1, "R2 valid one-hot", {m_vld, m_sel}, {1'b1, e});
            check(m_sel == e, tag_of(1'b0, hx, hy, dx, dy), m_sel, e);
          end
    m_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(m_vld == 1'b0, "R8 consumed, no header", m_vld, 0);

    // torus sweep
    for (int hx = 0; hx < 4; hx++)
      for (int hy = 0; hy < 3; hy++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 3; dy++) begin
            t_hx = 2'(hx); t_hy = 2'(hy); t_dx = 2'(dx); t_dy = 2'(dy);
            t_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            e = exp_sel(4, 3, 1'b1, hx, hy, dx, dy);
            check(t_vld == 1'b1 && $countones(t_sel) == 1, "R2 ring valid one-hot", {t_vld, t_sel}, {1'b1, e});
            check(t_sel == e, tag_of(1'b1, hx, hy, dx, dy), t_sel, e);
          end
    t_valid = 1'b0;

    // R7 tie: ring of 4, offset 2 goes positive
    t_hx = 2'd3; t_dx = 2'd1; t_hy = 2'd0; t_dy = 2'd0; t_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(t_sel == 5'b00010, "R7 half-ring tie positive", t_sel, 5'b00010);
    t_valid = 1'b0;

    // R8: stall holds select and refuses a new header
    @(negedge clk);
    sel_ack = 1'b0;
    m_hx = 2'd0; m_hy = 2'd0; m_dx = 2'd3; m_dy = 2'd0; m_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(m_sel == 5'b00010 && m_vld, "R8 first header held", m_sel, 5'b00010);
    check(m_ready == 1'b0, "R8 ready low while stalled", m_ready, 0);
    m_dx = 2'd0; m_dy = 2'd0;
    @(posedge clk);
    @(negedge clk);
    check(m_sel == 5'b00010, "R8 second header ignored", m_sel, 5'b00010);
    sel_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(m_sel == 5'b00001, "R8 accept after ack (R5)", m_sel, 5'b00001);
    m_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // R1: reset in mid-run clears a pending select
    sel_ack = 1'b0;
    m_dx = 2'd2; m_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(m_vld == 1'b0 && m_sel == 5'b0 && m_ready, "R1 mid-run reset", {m_ready, m_vld, m_sel}, 6'b100000);
    rst = 1'b0;
    sel_ack = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule